// File: doc/BRIEF.md
# PLL Frequency Lock Detector

This block checks whether a PLL has settled on the frequency it was programmed for. It watches the PLL clock from the reference clock domain. Over fixed measurement windows of 64 reference cycles it counts PLL edges. It then compares that count with the count the programmed multiply and divide settings predict. A lock flag in the reference domain rises once the count has been inside the tolerance band for several windows in a row. The flag stays high while the match holds.

The flag drops as soon as the match is lost. That happens on a window outside the band, on any change of the enable, multiplier or divider setting, when the PLL clock stops, or when the reference clock stops.

The PLL edge count crosses into the reference domain as a Gray-coded value. Reference activity reaches the PLL domain as a slow toggle. A loss of reference is reported back through a four-phase request and acknowledge pair, so it is seen in full even when the reference clock stops and later resumes.

Top module: `pll_lock_detect`

## Requirements
- R1: While reset is held, and on the first cycles after it, `lockFlag` is 0.
- R2: Multiplier code `mulSel` maps 0→6, 1→8, 2→10 and 3→14. Divider code `divCode` n in 0..6 selects divide by n+1. With a PLL clock of exactly reference×multiplier÷divider, the flag is 1 within 6×64+16 reference cycles of a setting change, for all 28 combinations.
- R3: A window matches when its PLL count N satisfies |N×divider − 64×multiplier| ≤ 2×divider. A PLL clock whose count is 4 above or 4 below the ideal count never produces lock. A clock whose count is 1 above the ideal count does produce lock.
- R4: Lock needs 4 matching windows in a row after a restart, so the flag is still 0 at 3×64 reference cycles after a setting change.
- R5: Once set, the flag stays 1 for as long as every window matches.
- R6: A single window out of tolerance clears the flag on the next reference cycle. Qualification then starts again from zero.
- R7: A change of `pllEn`, `mulSel` or `divCode` clears the flag on the next reference edge and restarts qualification.
- R8: With `pllEn` at 0, or with `divCode` equal to 7 (PLL off), the flag is 0.
- R9: If the synchronized PLL count does not move for 8 reference cycles, the flag is cleared.
- R10: When the PLL domain sees no reference activity for 32 PLL cycles, the flag reads 0 at once. After the reference resumes, lock returns only through a full new qualification.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Reference clock; lock flag domain |
| pllClk | input | 1 | PLL output clock under measurement |
| rstN | input | 1 | Active-low asynchronous reset, both domains |
| pllEn | input | 1 | PLL enable; 0 forces no lock |
| mulSel | input | 2 | Multiplier code (6, 8, 10, 14) |
| divCode | input | 3 | Divider code (n+1), 7 = PLL off |
| lockFlag | output | 1 | Frequency lock indication |

## Verification
A wrong qualification counter shows up at the port as a lock that rises after three windows or after five, which is a difference of 64 reference cycles. A tolerance comparison that is off by one count, or that uses the wrong multiplier, shows up within a few windows: a clock that is 4 counts away still locks, or an exact one never does. A watchdog or reference-loss path that is stuck shows up as a flag still high about a dozen reference cycles after a clock was stopped. A broken restart on a setting change leaves the flag high on the cycle after the change.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;

  // status from datapath to control
  typedef struct packed {
    logic winDone;   // a measurement window closed this cycle
    logic inTol;     // closing window count is within the band
    logic stallHit;  // PLL count frozen too long
    logic cfgChg;    // settings differ from last cycle
    logic active;    // PLL enabled and not switched off
    logic lostSeen;  // reference loss handshake in progress
  } lockStat_t;

  // strobes from control to datapath
  typedef struct packed {
    logic restartWin; // reopen the window from the current count
  } lockCmd_t;

  function automatic logic [3:0] mulOf(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd6;
      2'd1:    return 4'd8;
      2'd2:    return 4'd10;
      default: return 4'd14;
    endcase
  endfunction

  function automatic logic [2:0] divOf(input logic [2:0] code);
    return code + 3'd1;
  endfunction

endpackage

// File: rtl/pll_lock_pllside.sv
module pll_lock_pllside #(
  parameter int CNT_W   = 12,
  parameter int REF_TMO = 32
) (
  input  logic             pllClk,
  input  logic             rstN,
  input  logic             refTogIn,
  input  logic             ackIn,
  output logic [CNT_W-1:0] grayOut,
  output logic             lostOut
);
  localparam int TMO_W = $clog2(REF_TMO + 1);

  logic [CNT_W-1:0] binCnt;
  logic [CNT_W-1:0] binNext;
  logic [2:0]       togSync;
  logic [1:0]       ackSync;
  logic [TMO_W-1:0] quietCnt;

  assign binNext = binCnt + CNT_W'(1);

  // free-running edge counter published in Gray code
  always_ff @(posedge pllClk or negedge rstN) begin
    if (!rstN) begin
      binCnt  <= '0;
      grayOut <= '0;
    end else begin
      binCnt  <= binNext;
      grayOut <= binNext ^ (binNext >> 1);
    end
  end

  // reference activity monitor with sticky loss flag
  always_ff @(posedge pllClk or negedge rstN) begin
    if (!rstN) begin
      togSync  <= '0;
      ackSync  <= '0;
      quietCnt <= '0;
      lostOut  <= 1'b0;
    end else begin
      togSync <= {togSync[1:0], refTogIn};
      ackSync <= {ackSync[0], ackIn};
      if (togSync[2] != togSync[1]) begin
        quietCnt <= '0;
      end else if (quietCnt < TMO_W'(REF_TMO)) begin
        quietCnt <= quietCnt + TMO_W'(1);
      end
      if (ackSync[1]) begin
        lostOut <= 1'b0;
      end else if (quietCnt >= TMO_W'(REF_TMO)) begin
        lostOut <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pll_lock_datapath.sv
module pll_lock_datapath
  import pll_lock_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int WIN_LOG2  = 6,
  parameter int TOL       = 2,
  parameter int STALL_LIM = 8
) (
  input  logic             refClk,
  input  logic             rstN,
  input  logic             pllEn,
  input  logic [1:0]       mulSel,
  input  logic [2:0]       divCode,
  input  logic [CNT_W-1:0] grayIn,
  input  logic             lostIn,
  input  lockCmd_t         cmd,
  output lockStat_t        stat,
  output logic             refTogOut,
  output logic             ackOut
);
  localparam int PROD_W  = CNT_W + 4;
  localparam int STALL_W = $clog2(STALL_LIM + 1);

  logic [CNT_W-1:0]    graySync1, graySync2;
  logic [CNT_W-1:0]    binNow, binLast, snapCnt, delta;
  logic [WIN_LOG2-1:0] winCnt;
  logic [STALL_W-1:0]  stallCnt;
  logic [5:0]          cfgQ;
  logic [1:0]          lostSync;
  logic [1:0]          togDiv;
  logic [PROD_W-1:0]   prod, target, absDiff, tolLim;
  logic [3:0]          mulV;
  logic [2:0]          divV;

  // Gray to binary after the two-flop synchronizer
  always_comb begin
    binNow[CNT_W-1] = graySync2[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) begin
      binNow[i] = binNow[i+1] ^ graySync2[i];
    end
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      graySync1 <= '0;
      graySync2 <= '0;
      binLast   <= '0;
      stallCnt  <= '0;
      cfgQ      <= '0;
      lostSync  <= '0;
      ackOut    <= 1'b0;
      togDiv    <= '0;
    end else begin
      graySync1 <= grayIn;
      graySync2 <= graySync1;
      binLast   <= binNow;
      cfgQ      <= {pllEn, mulSel, divCode};
      lostSync  <= {lostSync[0], lostIn};
      ackOut    <= lostSync[1];
      togDiv    <= togDiv + 2'd1;
      if (binNow != binLast) begin
        stallCnt <= '0;
      end else if (stallCnt < STALL_W'(STALL_LIM)) begin
        stallCnt <= stallCnt + STALL_W'(1);
      end
    end
  end

  // measurement window
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      winCnt  <= '0;
      snapCnt <= '0;
    end else if (cmd.restartWin) begin
      winCnt  <= '0;
      snapCnt <= binNow;
    end else begin
      winCnt <= winCnt + WIN_LOG2'(1);
      if (stat.winDone) begin
        snapCnt <= binNow;
      end
    end
  end

  // tolerance test: |delta*div - 2^WIN_LOG2*mul| <= TOL*div
  always_comb begin
    mulV    = mulOf(mulSel);
    divV    = divOf(divCode);
    delta   = binNow - snapCnt;
    prod    = PROD_W'(delta) * PROD_W'(divV);
    target  = PROD_W'(mulV) << WIN_LOG2;
    absDiff = (prod > target) ? (prod - target) : (target - prod);
    tolLim  = PROD_W'(TOL) * PROD_W'(divV);
  end

  assign refTogOut     = togDiv[1];
  assign stat.winDone  = (winCnt == {WIN_LOG2{1'b1}}) && !cmd.restartWin;
  assign stat.inTol    = (absDiff <= tolLim);
  assign stat.stallHit = (stallCnt >= STALL_W'(STALL_LIM));
  assign stat.cfgChg   = ({pllEn, mulSel, divCode} != cfgQ);
  assign stat.active   = pllEn && (divCode != 3'd7);
  assign stat.lostSeen = lostSync[1] | ackOut;

endmodule

// File: rtl/pll_lock_control.sv
module pll_lock_control
  import pll_lock_pkg::*;
#(
  parameter int QUAL_WINS = 4
) (
  input  logic      refClk,
  input  logic      rstN,
  input  lockStat_t stat,
  output lockCmd_t  cmd,
  output logic      lockQ
);
  localparam int QW = $clog2(QUAL_WINS + 1);

  typedef enum logic [1:0] { ST_HOLD, ST_QUAL, ST_LOCK } lockState_t;

  lockState_t state;
  logic [QW-1:0] matchCnt;
  logic restartCond;

  assign restartCond = stat.cfgChg | !stat.active | stat.stallHit | stat.lostSeen;
  assign cmd.restartWin = restartCond || (state == ST_HOLD);
  assign lockQ = (state == ST_LOCK);

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_HOLD;
      matchCnt <= '0;
    end else if (restartCond) begin
      state    <= ST_HOLD;
      matchCnt <= '0;
    end else begin
      case (state)
        ST_HOLD: begin
          state    <= ST_QUAL;
          matchCnt <= '0;
        end
        ST_QUAL: begin
          if (stat.winDone) begin
            if (!stat.inTol) begin
              matchCnt <= '0;
            end else if (matchCnt == QW'(QUAL_WINS - 1)) begin
              state <= ST_LOCK;
            end else begin
              matchCnt <= matchCnt + QW'(1);
            end
          end
        end
        default: begin
          if (stat.winDone && !stat.inTol) begin
            state    <= ST_QUAL;
            matchCnt <= '0;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect
  import pll_lock_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int WIN_LOG2  = 6,
  parameter int TOL       = 2,
  parameter int QUAL_WINS = 4,
  parameter int STALL_LIM = 8,
  parameter int REF_TMO   = 32
) (
  input  logic       refClk,
  input  logic       pllClk,
  input  logic       rstN,
  input  logic       pllEn,
  input  logic [1:0] mulSel,
  input  logic [2:0] divCode,
  output logic       lockFlag
);
  lockStat_t        stat;
  lockCmd_t         cmd;
  logic [CNT_W-1:0] grayCnt;
  logic             lostPll, refTog, ackRef, lockQ;
  logic             winDone, inTol, stallHit;

  pll_lock_pllside #(.CNT_W(CNT_W), .REF_TMO(REF_TMO)) u_pll (
    .pllClk(pllClk), .rstN(rstN), .refTogIn(refTog), .ackIn(ackRef),
    .grayOut(grayCnt), .lostOut(lostPll)
  );

  pll_lock_datapath #(.CNT_W(CNT_W), .WIN_LOG2(WIN_LOG2), .TOL(TOL),
                      .STALL_LIM(STALL_LIM)) u_dp (
    .refClk(refClk), .rstN(rstN), .pllEn(pllEn), .mulSel(mulSel),
    .divCode(divCode), .grayIn(grayCnt), .lostIn(lostPll), .cmd(cmd),
    .stat(stat), .refTogOut(refTog), .ackOut(ackRef)
  );

  pll_lock_control #(.QUAL_WINS(QUAL_WINS)) u_ctl (
    .refClk(refClk), .rstN(rstN), .stat(stat), .cmd(cmd), .lockQ(lockQ)
  );

  assign winDone  = stat.winDone;
  assign inTol    = stat.inTol;
  assign stallHit = stat.stallHit;
  assign lockFlag = lockQ & ~lostPll;

endmodule

// File: rtl/pll_lock_detect_chk.sv
module pll_lock_detect_chk (
  input logic       refClk,
  input logic       rstN,
  input logic       pllEn,
  input logic [1:0] mulSel,
  input logic [2:0] divCode,
  input logic       lockFlag,
  input logic       winDone,
  input logic       inTol,
  input logic       stallHit
);
  // R7
  cfg_change_drop_chk: assert property (@(posedge refClk) disable iff (!rstN)
    !$stable({pllEn, mulSel, divCode}) |=> !lockFlag);

  // R8
  pll_off_nolock_chk: assert property (@(posedge refClk) disable iff (!rstN)
    (!pllEn || divCode == 3'd7) |=> !lockFlag);

  // R6
  bad_window_drop_chk: assert property (@(posedge refClk) disable iff (!rstN)
    (winDone && !inTol) |=> !lockFlag);

  // R9
  stall_drop_chk: assert property (@(posedge refClk) disable iff (!rstN)
    stallHit |=> !lockFlag);

  // R4
  rise_after_window_chk: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(lockFlag) |-> $past(winDone && inTol));

  // R1
  always @(posedge refClk) begin
    reset_low_chk: assert (rstN || !lockFlag);
  end
endmodule

bind pll_lock_detect pll_lock_detect_chk u_chk (.*);

// File: tb/pll_lock_detect_bench.sv
`timescale 1ns/1fs
module pll_lock_detect_bench;
  logic refClk = 1'b0;
  logic pllClk = 1'b0;
  logic rstN = 1'b0;
  logic pllEn = 1'b0;
  logic [1:0] mulSel = 2'd0;
  logic [2:0] divCode = 3'd0;
  logic lockFlag;

  bit refRun = 1'b1;
  bit pllRun = 1'b1;
  real pllHalf = 1.0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  pll_lock_detect u_pll_lock_detect (
    .refClk(refClk), .pllClk(pllClk), .rstN(rstN), .pllEn(pllEn),
    .mulSel(mulSel), .divCode(divCode), .lockFlag(lockFlag)
  );

  always #2 if (refRun) refClk = ~refClk;

  always begin
    if (pllRun) begin
      #(pllHalf) pllClk = ~pllClk;
    end else begin
      #1;
    end
  end

  function automatic int mulVal(input int code);
    case (code)
      0: return 6;
      1: return 8;
      2: return 10;
      default: return 14;
    endcase
  endfunction

  // PLL half period giving an ideal window count of 64*mul/div + off
  task automatic setPll(input int m, input int d, input int off);
    real ideal;
    ideal = 64.0 * mulVal(m) / (d + 1);
    pllHalf = 128.0 / (ideal + off);
  endtask

  task automatic waitRef(input int n);
    repeat (n) @(negedge refClk);
  endtask

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: lockFlag=%0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  localparam int WIN = 64;

  initial begin
    setPll(0, 0, 0);
    waitRef(10);
    check(lockFlag, 1'b0, "R1 in reset");
    rstN = 1'b1;
    waitRef(5);
    check(lockFlag, 1'b0, "R1 after reset");
    pllEn = 1'b1;

    // R2 R4 R5 R7: sweep all settings with an exact PLL clock
    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 7; d++) begin
        @(negedge refClk);
        mulSel = 2'(m);
        divCode = 3'(d);
        setPll(m, d, 0);
        waitRef(2);
        check(lockFlag, 1'b0, "R7 setting change");
        waitRef(3 * WIN - 2);
        check(lockFlag, 1'b0, "R4 before four windows");
        waitRef(3 * WIN + 16);
        check(lockFlag, 1'b1, "R2 lock with exact ratio");
        waitRef(3 * WIN);
        check(lockFlag, 1'b1, "R5 lock held");
      end
    end

    // R3: tolerance band on x14 /1 (ideal 896 counts)
    @(negedge refClk);
    mulSel = 2'd3;
    divCode = 3'd0;
    setPll(3, 0, 1);
    waitRef(7 * WIN);
    check(lockFlag, 1'b1, "R3 one count above accepted");
    setPll(3, 0, 4);
    waitRef(2 * WIN + 10);
    check(lockFlag, 1'b0, "R6 mismatching window drops lock");
    waitRef(8 * WIN);
    check(lockFlag, 1'b0, "R3 four counts above rejected");
    setPll(3, 0, -4);
    waitRef(8 * WIN);
    check(lockFlag, 1'b0, "R3 four counts below rejected");
    setPll(3, 0, 0);
    waitRef(7 * WIN);
    check(lockFlag, 1'b1, "R3 relock in band");

    // R8: disable and switch-off code
    @(negedge refClk);
    pllEn = 1'b0;
    waitRef(2);
    check(lockFlag, 1'b0, "R8 enable low");
    waitRef(6 * WIN);
    check(lockFlag, 1'b0, "R8 stays off while disabled");
    pllEn = 1'b1;
    waitRef(7 * WIN);
    check(lockFlag, 1'b1, "R8 relock after restart");
    @(negedge refClk);
    divCode = 3'd7;
    waitRef(6 * WIN);
    check(lockFlag, 1'b0, "R8 divider code 7 is off");
    divCode = 3'd0;
    waitRef(7 * WIN);
    check(lockFlag, 1'b1, "R8 relock after off code");

    // R9: PLL clock stops
    @(negedge refClk);
    pllRun = 1'b0;
    waitRef(16);
    check(lockFlag, 1'b0, "R9 PLL stall");
    waitRef(6 * WIN);
    check(lockFlag, 1'b0, "R9 stays low while stalled");
    pllRun = 1'b1;
    waitRef(7 * WIN);
    check(lockFlag, 1'b1, "R9 relock after PLL resumes");

    // R10: reference clock stops
    @(negedge refClk);
    refRun = 1'b0;
    #300;
    check(lockFlag, 1'b0, "R10 reference lost");
    #100;
    refRun = 1'b1;
    waitRef(3);
    check(lockFlag, 1'b0, "R10 low just after resume");
    waitRef(8 * WIN);
    check(lockFlag, 1'b1, "R10 relock after resume");

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #600000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule